// File: doc/BRIEF.md
# Word-to-Byte Bus Bridge

This block sits between a processor whose data bus only moves 16-bit words and a system bus where one address window holds 8-bit devices. The processor presents a word address (there is no byte-select bit on its side), a direction and write data. The bridge decodes the address into one of three regions. Boot ROM and scratchpad RAM accesses pass straight through to a 16-bit side bus in the same cycle.

Any access to the 8-bit window becomes two byte cycles on a separate narrow bus. The bridge creates the missing byte-select address bit itself. Each byte cycle is stretched by a parameterised number of wait cycles. On reads, the two returned bytes are merged back into one word.

The processor is held off with a ready flag until the access completes. Addresses that fall in no region complete at once with zero read data and no select.

Top module: `bb_word_byte_bridge`

## Requirements
- R1: After reset, with no request, `cpu_rdy`, `nb_rd`, `nb_wr`, `rom_cs` and `pad_cs` are all 0.
- R2: A request whose byte address is 0x0000..0x1FFF asserts `rom_cs` in the same cycle. It drives `wide_addr` with the word address and returns `wide_rdata` on `cpu_rdata` with `cpu_rdy` high in that cycle. It causes no narrow-bus strobe.
- R3: A request into the 256-byte scratchpad at byte base `PAD_BASE` (default 0xE000) asserts `pad_cs` and completes in the same cycle. A write there is presented as one full word with `wide_we` high. `rom_cs` and `pad_cs` are never high together.
- R4: A request into 0x8000..0x9FFF produces exactly two narrow byte cycles. Both carry the processor word address in `nb_addr[AW-1:1]`. The first has `nb_addr[0]`=0 and the second has `nb_addr[0]`=1, and the byte-select bit never returns to 0 within an access.
- R5: Each narrow byte cycle lasts `WAIT_CYC`+1 clock cycles. `cpu_rdy` stays low from the request until it rises 2*(`WAIT_CYC`+1)+1 cycles after the request was first seen. It is low in every cycle where a narrow strobe is active.
- R6: A narrow read returns the byte at the even address in `cpu_rdata[15:8]` and the byte at the odd address in `cpu_rdata[7:0]`, both presented in the cycle `cpu_rdy` rises.
- R7: A narrow write drives `cpu_wdata[15:8]` to the even address, then `cpu_wdata[7:0]` to the odd address. Each byte gets one single-cycle `nb_wr` pulse, in the last cycle of its byte cycle, for exactly two pulses per access.
- R8: A request outside all three regions asserts no select and no strobe. It completes in the same cycle with `cpu_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_waddr | input | AW-1 | Word address (byte address without its lowest bit) |
| cpu_wdata | input | DW | Write word |
| cpu_rdata | output | DW | Read word |
| cpu_rdy | output | 1 | Access complete |
| rom_cs | output | 1 | Boot ROM select |
| pad_cs | output | 1 | Scratchpad select |
| wide_we | output | 1 | Word write enable on the 16-bit side bus |
| wide_addr | output | AW-1 | Word address on the 16-bit side bus |
| wide_wdata | output | DW | Write word on the 16-bit side bus |
| wide_rdata | input | DW | Read word from the 16-bit side bus |
| nb_addr | output | AW | Byte address on the narrow bus, generated lowest bit |
| nb_rd | output | 1 | Narrow read strobe, high for the whole byte cycle |
| nb_wr | output | 1 | Narrow write pulse, last cycle of the byte cycle |
| nb_wdata | output | DW/2 | Narrow write byte |
| nb_rdata | input | DW/2 | Narrow read byte |

## Verification
The assertions assume the processor keeps `cpu_req`, address and direction steady until it sees `cpu_rdy`. They also assume it drops the request for at least one cycle before the next access, and that the scratchpad base does not overlap the 8-bit window. The bench drives every access through one task that honours this handshake. Random and directed accesses cover the window edges and the addresses just outside them. Narrow-bus activity is observed by a monitor that logs each strobe's address and byte per access.

// File: rtl/bb_pkg.sv
// Shared types for the word-to-byte bridge.
// Assumes: nothing beyond IEEE 1800-2017.
package bb_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HI   = 2'd1,
        SEQ_LO   = 2'd2,
        SEQ_DONE = 2'd3
    } seq_e;

    typedef struct packed {
        logic narrow;
        logic rom;
        logic pad;
    } region_t;

endpackage

// File: rtl/bb_region_decode.sv
// Address region decoder.
// Maps a processor word address onto ROM, scratchpad or the 8-bit window.
// Assumes: the windows do not overlap; all bounds are byte addresses.
module bb_region_decode
    import bb_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int unsigned ROM_LAST  = 32'h0000_1FFF,
    parameter int unsigned PAD_BASE  = 32'h0000_E000,
    parameter int unsigned PAD_BYTES = 256,
    parameter int unsigned NB_BASE   = 32'h0000_8000,
    parameter int unsigned NB_LAST   = 32'h0000_9FFF
) (
    input  logic [AW-2:0] waddr,
    output region_t       region
);

    localparam int unsigned PAD_LAST = PAD_BASE + PAD_BYTES - 1;

    logic [31:0] byte_addr;

    // Widen the word address to a byte address for range compares.
    always_comb begin
        byte_addr = 32'({waddr, 1'b0});
    end

    // Classify the byte address into one region.
    always_comb begin
        region.rom    = (byte_addr <= ROM_LAST);
        region.pad    = (byte_addr >= PAD_BASE) && (byte_addr <= PAD_LAST);
        region.narrow = (byte_addr >= NB_BASE) && (byte_addr <= NB_LAST);
    end

endmodule

// File: rtl/bb_byte_seq.sv
// Byte-cycle sequencer.
// Walks idle -> upper byte -> lower byte -> done.
// Each byte phase lasts WAIT_CYC+1 cycles.
// Assumes: start is only sampled in idle.
module bb_byte_seq
    import bb_pkg::*;
#(
    parameter int WAIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output seq_e state,
    output logic last
);

    localparam int CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;

    logic [CW-1:0] cnt_q;

    // Last cycle of the current byte phase.
    always_comb begin
        last = (cnt_q == CW'(WAIT_CYC));
    end

    // Phase state and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    cnt_q <= '0;
                    if (start) state <= SEQ_HI;
                end
                SEQ_HI: begin
                    if (last) begin
                        state <= SEQ_LO;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_LO: begin
                    if (last) begin
                        state <= SEQ_DONE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bb_word_latch.sv
// Request capture and read-byte assembly.
// Holds the accepted request for the whole split access.
// Keeps the even byte until the odd byte arrives.
// Assumes: start and capture strobes come from the sequencer.
module bb_word_latch #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cpu_we,
    input  logic [AW-2:0]   cpu_waddr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic            cap_hi,
    input  logic            cap_lo,
    input  logic [DW/2-1:0] nb_rdata,
    output logic            we_q,
    output logic [AW-2:0]   waddr_q,
    output logic [DW-1:0]   wdata_q,
    output logic [DW/2-1:0] hi_q,
    output logic [DW/2-1:0] lo_q
);

    // Capture the request when a split access begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else if (start) begin
            we_q    <= cpu_we;
            waddr_q <= cpu_waddr;
            wdata_q <= cpu_wdata;
        end
    end

    // Store each returned byte at the end of its byte cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (cap_hi) hi_q <= nb_rdata;
            if (cap_lo) lo_q <= nb_rdata;
        end
    end

endmodule

// File: rtl/bb_word_byte_bridge.sv
// Word-to-byte bus bridge, top level.
// ROM and scratchpad accesses pass through as one word in the same cycle.
// 8-bit window accesses become two byte cycles with a generated byte-select bit.
// Assumes: cpu_req and its address, direction and data are held until cpu_rdy;
// the request drops for a cycle between accesses.
module bb_word_byte_bridge
    import bb_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 16,
    parameter int          WAIT_CYC  = 2,
    parameter int unsigned ROM_LAST  = 32'h0000_1FFF,
    parameter int unsigned PAD_BASE  = 32'h0000_E000,
    parameter int unsigned PAD_BYTES = 256,
    parameter int unsigned NB_BASE   = 32'h0000_8000,
    parameter int unsigned NB_LAST   = 32'h0000_9FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_req,
    input  logic            cpu_we,
    input  logic [AW-2:0]   cpu_waddr,
    input  logic [DW-1:0]   cpu_wdata,
    output logic [DW-1:0]   cpu_rdata,
    output logic            cpu_rdy,
    output logic            rom_cs,
    output logic            pad_cs,
    output logic            wide_we,
    output logic [AW-2:0]   wide_addr,
    output logic [DW-1:0]   wide_wdata,
    input  logic [DW-1:0]   wide_rdata,
    output logic [AW-1:0]   nb_addr,
    output logic            nb_rd,
    output logic            nb_wr,
    output logic [DW/2-1:0] nb_wdata,
    input  logic [DW/2-1:0] nb_rdata
);

    localparam int BW = DW / 2;

    region_t       region;
    seq_e          state;
    logic          last;
    logic          idle;
    logic          busy;
    logic          start;
    logic          we_q;
    logic [AW-2:0] waddr_q;
    logic [DW-1:0] wdata_q;
    logic [BW-1:0] hi_q;
    logic [BW-1:0] lo_q;

    bb_region_decode #(
        .AW(AW), .ROM_LAST(ROM_LAST), .PAD_BASE(PAD_BASE),
        .PAD_BYTES(PAD_BYTES), .NB_BASE(NB_BASE), .NB_LAST(NB_LAST)
    ) u_dec (
        .waddr  (cpu_waddr),
        .region (region)
    );

    bb_byte_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .last  (last)
    );

    bb_word_latch #(.AW(AW), .DW(DW)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cpu_we    (cpu_we),
        .cpu_waddr (cpu_waddr),
        .cpu_wdata (cpu_wdata),
        .cap_hi    ((state == SEQ_HI) && last),
        .cap_lo    ((state == SEQ_LO) && last),
        .nb_rdata  (nb_rdata),
        .we_q      (we_q),
        .waddr_q   (waddr_q),
        .wdata_q   (wdata_q),
        .hi_q      (hi_q),
        .lo_q      (lo_q)
    );

    // Sequencer phase flags and split-access start.
    always_comb begin
        idle  = (state == SEQ_IDLE);
        busy  = (state == SEQ_HI) || (state == SEQ_LO);
        start = idle && cpu_req && region.narrow;
    end

    // Word-wide pass-through for ROM and scratchpad.
    always_comb begin
        rom_cs     = idle && cpu_req && region.rom;
        pad_cs     = idle && cpu_req && region.pad;
        wide_we    = cpu_we && (rom_cs || pad_cs);
        wide_addr  = cpu_waddr;
        wide_wdata = cpu_wdata;
    end

    // Narrow bus: generated select bit, byte steering and strobes.
    always_comb begin
        nb_addr  = {waddr_q, (state == SEQ_LO)};
        nb_wdata = (state == SEQ_LO) ? wdata_q[BW-1:0] : wdata_q[DW-1:BW];
        nb_rd    = busy && !we_q;
        nb_wr    = busy && we_q && last;
    end

    // Completion flag and returned word.
    always_comb begin
        cpu_rdy   = (idle && cpu_req && !region.narrow) || (state == SEQ_DONE);
        cpu_rdata = '0;
        if (state == SEQ_DONE) begin
            cpu_rdata = {hi_q, lo_q};
        end else if (rom_cs || pad_cs) begin
            cpu_rdata = wide_rdata;
        end
    end

endmodule

// File: rtl/bb_bridge_chk.sv
// Protocol checker for the word-to-byte bridge, bound to the top.
// Assumes: the processor handshake stated in the top header.
module bb_bridge_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_rdy,
    input logic          rom_cs,
    input logic          pad_cs,
    input logic          nb_rd,
    input logic          nb_wr,
    input logic [AW-1:0] nb_addr
);

    // R3: at most one wide select.
    p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, pad_cs}));

    // R2: wide selects never coincide with narrow strobes.
    p_wide_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs || pad_cs) |-> !(nb_rd || nb_wr));

    // R5: ready stays low while a byte cycle runs.
    p_wait_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_rd || nb_wr) |-> !cpu_rdy);

    // R4: word address bits stay steady through a read access.
    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_rd && $past(nb_rd)) |-> $stable(nb_addr[AW-1:1]));

    // R4: the generated bit never goes back from odd to even in an access.
    p_sel_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_rd && $past(nb_rd)) |-> (nb_addr[0] || !$past(nb_addr[0])));

    // R7: the even-byte write pulse lasts a single cycle.
    p_even_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nb_wr && !nb_addr[0]) |=> !(nb_wr && !nb_addr[0]));

    // R1: no strobe in the first cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> !(nb_rd || nb_wr));

endmodule

bind bb_word_byte_bridge bb_bridge_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_rdy (cpu_rdy),
    .rom_cs  (rom_cs),
    .pad_cs  (pad_cs),
    .nb_rd   (nb_rd),
    .nb_wr   (nb_wr),
    .nb_addr (nb_addr)
);

// File: tb/tb_bb_word_byte_bridge.sv
// Bench for the word-to-byte bridge: seeded random accesses plus directed edges,
// checked against bench-side memory shadows.
module tb_bb_word_byte_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WAIT_CYC = 2;
    localparam int NARROW_CYC = 2 * (WAIT_CYC + 1) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-2:0] cpu_waddr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rdy;
    logic          rom_cs;
    logic          pad_cs;
    logic          wide_we;
    logic [AW-2:0] wide_addr;
    logic [DW-1:0] wide_wdata;
    logic [DW-1:0] wide_rdata;
    logic [AW-1:0] nb_addr;
    logic          nb_rd;
    logic          nb_wr;
    logic [7:0]    nb_wdata;
    logic [7:0]    nb_rdata;

    int checks = 0;
    int errors = 0;

    logic [15:0] pad_mem [128];
    logic [15:0] pad_exp [128];
    logic [7:0]  nb_mem  [8192];
    logic [7:0]  nb_exp  [8192];

    // Monitor log of narrow activity for the current access.
    int          wr_cnt;
    logic [15:0] wr_addr [4];
    logic [7:0]  wr_data [4];
    logic        rd_even, rd_odd, rd_bad, nb_any;
    logic [14:0] mon_waddr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bb_word_byte_bridge #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rdy(cpu_rdy), .rom_cs(rom_cs), .pad_cs(pad_cs), .wide_we(wide_we),
        .wide_addr(wide_addr), .wide_wdata(wide_wdata), .wide_rdata(wide_rdata),
        .nb_addr(nb_addr), .nb_rd(nb_rd), .nb_wr(nb_wr), .nb_wdata(nb_wdata),
        .nb_rdata(nb_rdata)
    );

    function automatic logic [15:0] rom_word(input logic [14:0] wa);
        return 16'(wa * 16'h9E37) ^ 16'h5A5A;
    endfunction

    function automatic logic [7:0] nb_init(input int i);
        return 8'((i * 37) ^ (i >> 5));
    endfunction

    // Memory models.
    always_comb begin
        if (rom_cs)      wide_rdata = rom_word(wide_addr);
        else if (pad_cs) wide_rdata = pad_mem[wide_addr[6:0]];
        else             wide_rdata = 16'hDEAD;
        nb_rdata = nb_mem[nb_addr[12:0]];
    end

    always @(posedge clk) begin
        if (pad_cs && wide_we) pad_mem[wide_addr[6:0]] <= wide_wdata;
        if (nb_wr) begin
            nb_mem[nb_addr[12:0]] <= nb_wdata;
            if (wr_cnt < 4) begin
                wr_addr[wr_cnt] <= nb_addr;
                wr_data[wr_cnt] <= nb_wdata;
            end
            wr_cnt <= wr_cnt + 1;
        end
        if (nb_rd || nb_wr) nb_any <= 1'b1;
        if (nb_rd) begin
            if (nb_addr[15:1] != mon_waddr) rd_bad <= 1'b1;
            if (nb_addr[0]) rd_odd <= 1'b1;
            else if (rd_odd) rd_bad <= 1'b1;
            else rd_even <= 1'b1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One processor access with full checking. kind: 0 rom, 1 pad, 2 narrow, 3 none.
    task automatic access(input logic we, input logic [14:0] wa, input logic [15:0] wd);
        int cyc;
        int kind;
        logic [15:0] rd;
        logic        rom_seen, pad_seen;
        int          off;
        logic [15:0] ba;
        ba = {wa, 1'b0};
        if (ba <= 16'h1FFF) kind = 0;
        else if (ba >= 16'hE000 && ba <= 16'hE0FF) kind = 1;
        else if (ba >= 16'h8000 && ba <= 16'h9FFF) kind = 2;
        else kind = 3;
        @(negedge clk);
        wr_cnt = 0; rd_even = 0; rd_odd = 0; rd_bad = 0; nb_any = 0;
        mon_waddr = wa;
        cpu_req = 1'b1; cpu_we = we; cpu_waddr = wa; cpu_wdata = wd;
        #1;
        rom_seen = rom_cs; pad_seen = pad_cs;
        cyc = 0;
        while (!cpu_rdy && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        off = int'(ba[12:0]);
        case (kind)
            0: begin
                check(cyc == 0 && rom_seen && !pad_seen, "R2 rom select/latency", cyc, 0);
                check(!nb_any, "R2 no narrow strobe", nb_any, 0);
                if (!we) check(rd == rom_word(wa), "R2 rom data", rd, rom_word(wa));
            end
            1: begin
                check(cyc == 0 && pad_seen && !rom_seen, "R3 pad select/latency", cyc, 0);
                check(!nb_any, "R3 no narrow strobe", nb_any, 0);
                if (we) pad_exp[wa[6:0]] = wd;
                else check(rd == pad_exp[wa[6:0]], "R3 pad data", rd, pad_exp[wa[6:0]]);
            end
            2: begin
                check(cyc == NARROW_CYC, "R5 narrow latency", cyc, NARROW_CYC);
                if (we) begin
                    check(wr_cnt == 2, "R7 write pulse count", wr_cnt, 2);
                    check(wr_addr[0] == ba && wr_data[0] == wd[15:8],
                          "R7 even byte first", {wr_addr[0], wr_data[0]}, {ba, wd[15:8]});
                    check(wr_addr[1] == (ba | 16'h1) && wr_data[1] == wd[7:0],
                          "R4 odd byte second", {wr_addr[1], wr_data[1]}, {ba | 16'h1, wd[7:0]});
                    nb_exp[off] = wd[15:8];
                    nb_exp[off + 1] = wd[7:0];
                end else begin
                    check(rd_even && rd_odd && !rd_bad, "R4 byte cycle order",
                          {rd_even, rd_odd, rd_bad}, 3'b110);
                    check(rd == {nb_exp[off], nb_exp[off + 1]}, "R6 assembled word",
                          rd, {nb_exp[off], nb_exp[off + 1]});
                    check(wr_cnt == 0, "R7 no write pulse on read", wr_cnt, 0);
                end
            end
            default: begin
                check(cyc == 0 && !rom_seen && !pad_seen && !nb_any,
                      "R8 unmapped completes quietly", cyc, 0);
                check(rd == 16'h0, "R8 unmapped data", rd, 0);
            end
        endcase
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            pad_mem[i] = 16'(i * 16'h0101 + 7);
            pad_exp[i] = 16'(i * 16'h0101 + 7);
        end
        for (int i = 0; i < 8192; i++) begin
            nb_mem[i] = nb_init(i);
            nb_exp[i] = nb_init(i);
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpu_rdy && !nb_rd && !nb_wr && !rom_cs && !pad_cs, "R1 reset state",
              {cpu_rdy, nb_rd, nb_wr, rom_cs, pad_cs}, 0);

        // Directed edges.
        access(1'b0, 15'h0000, 16'h0);
        access(1'b0, 15'h0FFF, 16'h0);
        access(1'b1, 15'h7000, 16'hA55A);
        access(1'b0, 15'h7000, 16'h0);
        access(1'b1, 15'h707F, 16'h1234);
        access(1'b0, 15'h707F, 16'h0);
        access(1'b1, 15'h4000, 16'hBEEF);
        access(1'b0, 15'h4000, 16'h0);
        access(1'b1, 15'h4FFF, 16'hC0DE);
        access(1'b0, 15'h4FFF, 16'h0);
        access(1'b0, 15'h3FFF, 16'h0);
        access(1'b0, 15'h5000, 16'h0);
        access(1'b1, 15'h1000, 16'hFFFF);

        // Seeded random mix.
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [14:0] wa;
            r = int'($urandom_range(0, 9));
            if (r < 2)      wa = 15'($urandom_range(0, 16'h0FFF));
            else if (r < 4) wa = 15'(16'h7000 + $urandom_range(0, 127));
            else if (r < 9) wa = 15'(16'h4000 + $urandom_range(0, 16'h0FFF));
            else            wa = 15'(16'h2000 + $urandom_range(0, 16'h1FFF));
            access(1'($urandom_range(0, 1)), wa, 16'($urandom()));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule